// File: doc/BRIEF.md
# Chess position bitstream packer

This block turns one chess position into a compact, variable-length serial record. The position arrives as a set of 64-square bitboards: the two colours, the six piece types, an en passant target bitboard and a bitboard of rooks that still hold castling rights. It also takes a side-to-move bit and a 7-bit halfmove counter. A one-cycle start strobe captures all of these inputs. The block then walks a fixed sequence of fields and writes at most one field per cycle into a word packer. The packer presents 64-bit words on a valid/ready stream and marks the final word.

Most fields are built by masked bit extraction. The bits of a source bitboard that lie under a mask are gathered, in ascending square order, into the low end of the field. The field is as long as the mask's population count. The placement fields use a remaining-occupancy mask, and each piece type is removed from that mask once it has been written. Every later field is therefore shorter, and the record length depends on the position. King placement is never written, because whatever is left of the occupancy at the end of the placement fields must be the kings. The block compares that remainder with the king input and raises a flag if they differ.

Top module: `posPacker`

## Requirements
- R1: After reset, `outValid`, `busy` and `kingErr` are all 0.
- R2: The stream opens with a 64-bit field equal to `whiteBb | blackBb`.
- R3: The second field is the white bitboard extracted under the occupancy. Its length is the occupancy's population count. Extraction puts the lowest-numbered selected square at field bit 0. The black bitboard is not written on its own.
- R4: Next come pawns, knights, bishops, rooks and queens, in that order. Each is extracted under the remaining occupancy, with length equal to its population count. The remaining occupancy starts as the full occupancy and has the piece bitboard XORed out after each of these fields.
- R5: After the placement fields come one bit of `sideToMove`, then one en passant presence bit. The presence bit is 1 exactly when `epSquareBb` is nonzero.
- R6: The en passant field is written only when the presence bit is 1. It is `epSquareBb` extracted under the candidate mask `((whiteBb & pawnBb & 64'h00000000FF000000) << 8) | ((blackBb & pawnBb & 64'h0000FF0000000000) >> 8)`, with length equal to the mask's population count.
- R7: Next comes `castleRookBb` extracted under `rookBb`, with length `popcount(rookBb)`. The last field is the 7-bit `halfMove`.
- R8: Fields are concatenated LSB first. Record bit k appears at bit k mod 64 of output word k/64. The final word is zero above the record's end, and `outLast` is 1 on that word only.
- R9: While `outValid` is 1 and `outReady` is 0, `outData`, `outLast` and `outValid` hold their values.
- R10: At the end of a record, `kingErr` is 1 exactly when the occupancy left after the queen field differs from `kingBb`. An accepted start clears it.
- R11: A start strobe while `busy` is 1 is ignored. Inputs are captured at the accepted start, so later changes to them do not alter the record.
- R12: `busy` rises in the cycle after an accepted start and falls after the handshake of the final word. `outValid` is 0 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin a record (when idle) |
| whiteBb | input | 64 | White pieces |
| blackBb | input | 64 | Black pieces |
| pawnBb | input | 64 | Pawns of both colours |
| knightBb | input | 64 | Knights of both colours |
| bishopBb | input | 64 | Bishops of both colours |
| rookBb | input | 64 | Rooks of both colours |
| queenBb | input | 64 | Queens of both colours |
| kingBb | input | 64 | Kings of both colours (checked, not written) |
| sideToMove | input | 1 | Side to move bit |
| epSquareBb | input | 64 | En passant target square, zero if none |
| castleRookBb | input | 64 | Rooks that keep castling rights |
| halfMove | input | 7 | Halfmove counter |
| outReady | input | 1 | Consumer accepts the current word |
| busy | output | 1 | A record is in progress |
| outValid | output | 1 | `outData` holds a word |
| outData | output | 64 | Packed record word |
| outLast | output | 1 | Current word is the last of the record |
| kingErr | output | 1 | Leftover occupancy did not match the king input |

## Verification
Random positions with sparse occupancy exercise the shrinking mask: each field length differs from the one before, so a wrong field order or a missed XOR moves every later bit. An empty board yields the shortest record, which reduces to the occupancy, the two flag bits and the counter. A board filled only by white pawns produces full-length fields followed by fields of zero length. Further positions cover en passant squares inside and outside the candidate mask, a deliberately wrong king bitboard, a start strobe with altered inputs during a record, and long stretches of back-pressure. These separate errors in extraction, occupancy update, optional-field skipping, error flagging, input capture and word holding.

// File: rtl/posPackPkg.sv
package posPackPkg;
  localparam int BOARD_W = 64;
  localparam int LEN_W   = $clog2(BOARD_W + 1);
  // en passant candidate rows
  localparam logic [BOARD_W-1:0] EP_ROW_WHITE = 64'h0000_0000_FF00_0000;
  localparam logic [BOARD_W-1:0] EP_ROW_BLACK = 64'h0000_FF00_0000_0000;

  typedef enum logic [3:0] {
    FS_IDLE, FS_OCC, FS_WHITE, FS_PAWN, FS_KNIGHT, FS_BISHOP, FS_ROOK,
    FS_QUEEN, FS_SIDE, FS_EPFLAG, FS_EPSQ, FS_CASTLE, FS_HALF, FS_FLUSH
  } fieldSel_e;

  typedef struct packed {
    logic      load;
    logic      append;
    fieldSel_e sel;
  } ctrlStrobe_t;

  function automatic logic [LEN_W-1:0] popCount(input logic [BOARD_W-1:0] v);
    logic [LEN_W-1:0] c;
    c = '0;
    for (int i = 0; i < BOARD_W; i++) c = c + LEN_W'(v[i]);
    return c;
  endfunction

  // gather bits of src under mask, ascending, into the low end
  function automatic logic [BOARD_W-1:0] extractBits(input logic [BOARD_W-1:0] src,
                                                      input logic [BOARD_W-1:0] mask);
    logic [BOARD_W-1:0] r;
    logic [LEN_W-1:0]   k;
    r = '0;
    k = '0;
    for (int i = 0; i < BOARD_W; i++) begin
      if (mask[i]) begin
        r[k[LEN_W-2:0]] = src[i];
        k = k + 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/posPackCtrl.sv
module posPackCtrl
  import posPackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        canAccept,
  input  logic        epPresent,
  input  logic        lastFire,
  output ctrlStrobe_t strobe,
  output logic        flushing,
  output logic        busy
);
  fieldSel_e state, nextState;
  logic      inField;

  assign inField = (state != FS_IDLE) && (state != FS_FLUSH);

  always_comb begin
    strobe.load   = (state == FS_IDLE) && start;
    strobe.append = inField && canAccept;
    strobe.sel    = state;
    flushing      = (state == FS_FLUSH);
    busy          = (state != FS_IDLE);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      FS_IDLE:   if (start) nextState = FS_OCC;
      FS_OCC:    if (canAccept) nextState = FS_WHITE;
      FS_WHITE:  if (canAccept) nextState = FS_PAWN;
      FS_PAWN:   if (canAccept) nextState = FS_KNIGHT;
      FS_KNIGHT: if (canAccept) nextState = FS_BISHOP;
      FS_BISHOP: if (canAccept) nextState = FS_ROOK;
      FS_ROOK:   if (canAccept) nextState = FS_QUEEN;
      FS_QUEEN:  if (canAccept) nextState = FS_SIDE;
      FS_SIDE:   if (canAccept) nextState = FS_EPFLAG;
      FS_EPFLAG: if (canAccept) nextState = epPresent ? FS_EPSQ : FS_CASTLE;
      FS_EPSQ:   if (canAccept) nextState = FS_CASTLE;
      FS_CASTLE: if (canAccept) nextState = FS_HALF;
      FS_HALF:   if (canAccept) nextState = FS_FLUSH;
      FS_FLUSH:  if (lastFire) nextState = FS_IDLE;
      default:   nextState = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= FS_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/posPackDatapath.sv
module posPackDatapath
  import posPackPkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [BOARD_W-1:0] whiteBb,
  input  logic [BOARD_W-1:0] blackBb,
  input  logic [BOARD_W-1:0] pawnBb,
  input  logic [BOARD_W-1:0] knightBb,
  input  logic [BOARD_W-1:0] bishopBb,
  input  logic [BOARD_W-1:0] rookBb,
  input  logic [BOARD_W-1:0] queenBb,
  input  logic [BOARD_W-1:0] kingBb,
  input  logic               sideToMove,
  input  logic [BOARD_W-1:0] epSquareBb,
  input  logic [BOARD_W-1:0] castleRookBb,
  input  logic [HALF_W-1:0]  halfMove,
  output logic [BOARD_W-1:0] fieldVal,
  output logic [LEN_W-1:0]   fieldLen,
  output logic               epPresent,
  output logic               kingErr
);
  logic [BOARD_W-1:0] whiteQ, pawnQ, knightQ, bishopQ, rookQ, queenQ, kingQ;
  logic [BOARD_W-1:0] epQ, castleQ, occQ, remOcc;
  logic               sideQ;
  logic [HALF_W-1:0]  halfQ;
  logic [BOARD_W-1:0] epCand, extSrc, extMask, pieceSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      whiteQ <= '0; pawnQ <= '0; knightQ <= '0; bishopQ <= '0;
      rookQ <= '0; queenQ <= '0; kingQ <= '0; epQ <= '0; castleQ <= '0;
      occQ <= '0; remOcc <= '0; sideQ <= 1'b0; halfQ <= '0; kingErr <= 1'b0;
    end else if (strobe.load) begin
      whiteQ  <= whiteBb;  pawnQ <= pawnBb;   knightQ <= knightBb;
      bishopQ <= bishopBb; rookQ <= rookBb;   queenQ  <= queenBb;
      kingQ   <= kingBb;   epQ   <= epSquareBb; castleQ <= castleRookBb;
      sideQ   <= sideToMove; halfQ <= halfMove;
      occQ    <= whiteBb | blackBb;
      remOcc  <= whiteBb | blackBb;
      kingErr <= 1'b0;
      epCandQ <= ((whiteBb & pawnBb & EP_ROW_WHITE) << 8)
               | ((blackBb & pawnBb & EP_ROW_BLACK) >> 8);
    end else if (strobe.append) begin
      if (strobe.sel inside {FS_PAWN, FS_KNIGHT, FS_BISHOP, FS_ROOK, FS_QUEEN})
        remOcc <= remOcc ^ pieceSel;
      if (strobe.sel == FS_QUEEN)
        kingErr <= ((remOcc ^ queenQ) != kingQ);
    end
  end

  logic [BOARD_W-1:0] epCandQ;
  assign epCand    = epCandQ;
  assign epPresent = |epQ;

  always_comb begin
    unique case (strobe.sel)
      FS_PAWN:   pieceSel = pawnQ;
      FS_KNIGHT: pieceSel = knightQ;
      FS_BISHOP: pieceSel = bishopQ;
      FS_ROOK:   pieceSel = rookQ;
      FS_QUEEN:  pieceSel = queenQ;
      default:   pieceSel = '0;
    endcase
  end

  // one shared extractor, operands chosen by the current field
  always_comb begin
    extSrc  = pieceSel;
    extMask = remOcc;
    unique case (strobe.sel)
      FS_WHITE:  begin extSrc = whiteQ;  extMask = occQ;   end
      FS_EPSQ:   begin extSrc = epQ;     extMask = epCand; end
      FS_CASTLE: begin extSrc = castleQ; extMask = rookQ;  end
      default:   ;
    endcase
  end

  always_comb begin
    fieldVal = extractBits(extSrc, extMask);
    fieldLen = popCount(extMask);
    unique case (strobe.sel)
      FS_OCC:    begin fieldVal = occQ; fieldLen = LEN_W'(BOARD_W); end
      FS_SIDE:   begin fieldVal = BOARD_W'(sideQ); fieldLen = LEN_W'(1); end
      FS_EPFLAG: begin fieldVal = BOARD_W'(epPresent); fieldLen = LEN_W'(1); end
      FS_HALF:   begin fieldVal = BOARD_W'(halfQ); fieldLen = LEN_W'(HALF_W); end
      default:   ;
    endcase
  end
endmodule

// File: rtl/posPackWordPacker.sv
module posPackWordPacker
  import posPackPkg::*;
#(
  parameter int WORD_W = BOARD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              append,
  input  logic              flushing,
  input  logic [WORD_W-1:0] fieldVal,
  input  logic [LEN_W-1:0]  fieldLen,
  input  logic              outReady,
  output logic              canAccept,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic              outLast,
  output logic              lastFire
);
  localparam int ACC_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(ACC_W) + 1;
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  fill;
  logic [WORD_W-1:0] lenMask;
  logic              fire;

  always_comb begin
    if (fieldLen >= LEN_W'(WORD_W)) lenMask = '1;
    else lenMask = ({{(WORD_W-1){1'b0}}, 1'b1} << fieldLen) - 1'b1;
  end

  assign canAccept = (fill < WORD_CNT) && !flushing;
  assign outValid  = (fill >= WORD_CNT) || (flushing && (fill != '0));
  assign outLast   = flushing && (fill != '0) && (fill <= WORD_CNT);
  assign outData   = acc[WORD_W-1:0];
  assign fire      = outValid && outReady;
  assign lastFire  = fire && outLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      fill <= '0;
    end else if (fire) begin
      acc  <= acc >> WORD_W;
      fill <= (fill >= WORD_CNT) ? fill - WORD_CNT : '0;
    end else if (append) begin
      acc  <= acc | ({{WORD_W{1'b0}}, fieldVal & lenMask} << fill);
      fill <= fill + CNT_W'(fieldLen);
    end
  end
endmodule

// File: rtl/posPacker.sv
module posPacker
  import posPackPkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BOARD_W-1:0] whiteBb,
  input  logic [BOARD_W-1:0] blackBb,
  input  logic [BOARD_W-1:0] pawnBb,
  input  logic [BOARD_W-1:0] knightBb,
  input  logic [BOARD_W-1:0] bishopBb,
  input  logic [BOARD_W-1:0] rookBb,
  input  logic [BOARD_W-1:0] queenBb,
  input  logic [BOARD_W-1:0] kingBb,
  input  logic               sideToMove,
  input  logic [BOARD_W-1:0] epSquareBb,
  input  logic [BOARD_W-1:0] castleRookBb,
  input  logic [HALF_W-1:0]  halfMove,
  input  logic               outReady,
  output logic               busy,
  output logic               outValid,
  output logic [BOARD_W-1:0] outData,
  output logic               outLast,
  output logic               kingErr
);
  ctrlStrobe_t        strobe;
  logic               flushing, canAccept, epPresent, lastFire;
  logic [BOARD_W-1:0] fieldVal;
  logic [LEN_W-1:0]   fieldLen;

  posPackCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .canAccept(canAccept),
    .epPresent(epPresent), .lastFire(lastFire), .strobe(strobe),
    .flushing(flushing), .busy(busy)
  );

  posPackDatapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .whiteBb(whiteBb), .blackBb(blackBb), .pawnBb(pawnBb), .knightBb(knightBb),
    .bishopBb(bishopBb), .rookBb(rookBb), .queenBb(queenBb), .kingBb(kingBb),
    .sideToMove(sideToMove), .epSquareBb(epSquareBb), .castleRookBb(castleRookBb),
    .halfMove(halfMove), .fieldVal(fieldVal), .fieldLen(fieldLen),
    .epPresent(epPresent), .kingErr(kingErr)
  );

  posPackWordPacker #(.WORD_W(BOARD_W)) u_pack (
    .clk(clk), .rstN(rstN), .append(strobe.append), .flushing(flushing),
    .fieldVal(fieldVal), .fieldLen(fieldLen), .outReady(outReady),
    .canAccept(canAccept), .outValid(outValid), .outData(outData),
    .outLast(outLast), .lastFire(lastFire)
  );
endmodule

// File: rtl/posPackerChk.sv
module posPackerChk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        outValid,
  input logic        outReady,
  input logic        outLast,
  input logic [63:0] outData,
  input logic        kingErr
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);

  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> !kingErr);

  assert_last_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !busy);
endmodule

bind posPacker posPackerChk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .outValid(outValid),
  .outReady(outReady), .outLast(outLast), .outData(outData), .kingErr(kingErr)
);

// File: tb/test_posPacker.sv
module test_posPacker;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] w, b, p, n, bi, r, q, k, ep, ca;
    logic        stm;
    logic [6:0]  half;
  } pos_t;

  logic clk = 0, rstN = 0, start = 0, outReady = 0;
  logic [63:0] whiteBb = 0, blackBb = 0, pawnBb = 0, knightBb = 0, bishopBb = 0;
  logic [63:0] rookBb = 0, queenBb = 0, kingBb = 0, epSquareBb = 0, castleRookBb = 0;
  logic        sideToMove = 0;
  logic [6:0]  halfMove = 0;
  logic        busy, outValid, outLast, kingErr;
  logic [63:0] outData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posPacker i_posPacker (
    .clk(clk), .rstN(rstN), .start(start), .whiteBb(whiteBb), .blackBb(blackBb),
    .pawnBb(pawnBb), .knightBb(knightBb), .bishopBb(bishopBb), .rookBb(rookBb),
    .queenBb(queenBb), .kingBb(kingBb), .sideToMove(sideToMove),
    .epSquareBb(epSquareBb), .castleRookBb(castleRookBb), .halfMove(halfMove),
    .outReady(outReady), .busy(busy), .outValid(outValid), .outData(outData),
    .outLast(outLast), .kingErr(kingErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int refPop(input logic [63:0] v);
    int c = 0;
    for (int i = 0; i < 64; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [63:0] refExtract(input logic [63:0] src, input logic [63:0] mask);
    logic [63:0] r = '0;
    int k = 0;
    for (int i = 0; i < 64; i++) if (mask[i]) begin r[k] = src[i]; k++; end
    return r;
  endfunction

  // expected record built from R2..R7, packed per R8
  task automatic buildExp(input pos_t p, output logic [1023:0] s, output int nb, output bit err);
    logic [63:0] occ, rem, cand;
    logic [63:0] pcs [5];
    s = '0; nb = 0;
    occ = p.w | p.b;
    for (int i = 0; i < 64; i++) s[nb+i] = occ[i];
    nb += 64;
    begin
      logic [63:0] v = refExtract(p.w, occ);
      int l = refPop(occ);
      for (int i = 0; i < l; i++) s[nb+i] = v[i];
      nb += l;
    end
    pcs[0] = p.p; pcs[1] = p.n; pcs[2] = p.bi; pcs[3] = p.r; pcs[4] = p.q;
    rem = occ;
    for (int t = 0; t < 5; t++) begin
      logic [63:0] v = refExtract(pcs[t], rem);
      int l = refPop(rem);
      for (int i = 0; i < l; i++) s[nb+i] = v[i];
      nb += l;
      rem ^= pcs[t];
    end
    err = (rem != p.k);
    s[nb] = p.stm; nb++;
    s[nb] = |p.ep; nb++;
    if (|p.ep) begin
      logic [63:0] v;
      int l;
      cand = ((p.w & p.p & 64'h00000000FF000000) << 8) | ((p.b & p.p & 64'h0000FF0000000000) >> 8);
      v = refExtract(p.ep, cand);
      l = refPop(cand);
      for (int i = 0; i < l; i++) s[nb+i] = v[i];
      nb += l;
    end
    begin
      logic [63:0] v = refExtract(p.ca, p.r);
      int l = refPop(p.r);
      for (int i = 0; i < l; i++) s[nb+i] = v[i];
      nb += l;
    end
    for (int i = 0; i < 7; i++) s[nb+i] = p.half[i];
    nb += 7;
  endtask

  task automatic drive(input pos_t p);
    whiteBb = p.w; blackBb = p.b; pawnBb = p.p; knightBb = p.n; bishopBb = p.bi;
    rookBb = p.r; queenBb = p.q; kingBb = p.k; epSquareBb = p.ep; castleRookBb = p.ca;
    sideToMove = p.stm; halfMove = p.half;
  endtask

  function automatic pos_t randPos();
    pos_t p;
    logic [63:0] cand;
    p.w = 0; p.b = 0; p.p = 0; p.n = 0; p.bi = 0; p.r = 0; p.q = 0; p.k = 0;
    for (int sq = 0; sq < 64; sq++) begin
      if ($urandom % 8 < 3) begin
        int t = $urandom % 6;
        if ($urandom % 2) p.w[sq] = 1; else p.b[sq] = 1;
        case (t)
          0: p.p[sq] = 1;  1: p.n[sq] = 1; 2: p.bi[sq] = 1;
          3: p.r[sq] = 1;  4: p.q[sq] = 1; default: p.k[sq] = 1;
        endcase
      end
    end
    cand = ((p.w & p.p & 64'h00000000FF000000) << 8) | ((p.b & p.p & 64'h0000FF0000000000) >> 8);
    p.ep = 0;
    case ($urandom % 3)
      0: p.ep = 64'd1 << ($urandom % 64);
      1: if (cand != 0) begin
           int pick = $urandom % refPop(cand);
           for (int i = 0; i < 64; i++) if (cand[i]) begin
             if (pick == 0) p.ep[i] = 1;
             pick--;
           end
         end
      default: ;
    endcase
    p.ca = p.r & {$urandom, $urandom};
    p.stm = $urandom % 2;
    p.half = 7'($urandom);
    return p;
  endfunction

  task automatic runPos(input pos_t p, input int readyPct, input bit disturb);
    logic [1023:0] s;
    int nb, nw, widx, guard;
    bit expErr, done, stalled;
    logic [63:0] heldData;
    logic heldLast;
    buildExp(p, s, nb, expErr);
    nw = (nb + 63) / 64;
    @(negedge clk);
    drive(p); start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R12 busy after start", 64'(busy), 64'd1);
    if (disturb) begin
      pos_t j = randPos();
      drive(j); start = 1;
      @(negedge clk);
      start = 0;
    end
    widx = 0; done = 0; stalled = 0; guard = 0; heldData = 0; heldLast = 0;
    while (!done && guard < 2000) begin
      bit rdy = (($urandom % 100) < readyPct);
      guard++;
      outReady = rdy;
      #1;
      if (stalled) begin
        check(outValid === 1'b1 && outData === heldData && outLast === heldLast,
              "R9 word held under stall", outData, heldData);
        stalled = 0;
      end
      if (outValid === 1'b1) begin
        if (rdy) begin
          check(outData === s[widx*64 +: 64], disturb ? "R11 captured inputs" : "R2-R8 word",
                outData, s[widx*64 +: 64]);
          check(outLast === (widx == nw-1), "R8 last marker", 64'(outLast), 64'(widx == nw-1));
          widx++;
          if (outLast === 1'b1) done = 1;
        end else begin
          stalled = 1; heldData = outData; heldLast = outLast;
        end
      end
      @(negedge clk);
    end
    outReady = 0;
    check(widx == nw, "R8 word count", 64'(widx), 64'(nw));
    check(busy === 1'b0, "R12 busy falls after last", 64'(busy), 64'd0);
    check(kingErr === expErr, "R10 king mismatch flag", 64'(kingErr), 64'(expErr));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pos_t p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid reset", 64'(outValid), 0);
    check(busy === 1'b0, "R1 busy reset", 64'(busy), 0);
    check(kingErr === 1'b0, "R1 kingErr reset", 64'(kingErr), 0);

    // empty board: shortest record (R2 R5 R7)
    p = '{default: '0}; p.half = 7'h5A; p.stm = 1;
    runPos(p, 100, 0);

    // all white pawns: full then zero-length fields (R3 R4)
    p = '{default: '0}; p.w = '1; p.p = '1; p.half = 7'h7F;
    runPos(p, 100, 0);

    // en passant candidate present (R6): white pawn on square 28, target 36
    p = '{default: '0};
    p.w = 64'h0000_0000_1000_0010; p.p = 64'h0000_0000_1000_0000; p.k = 64'h0000_0000_0000_0010;
    p.b = 64'h1000_0000_0000_0000; p.k |= 64'h1000_0000_0000_0000;
    p.ep = 64'h0000_0010_0000_0000; p.half = 7'd3;
    runPos(p, 100, 0);

    // king mismatch (R10), then a clean position clears it
    p = randPos(); p.k = p.k ^ 64'h8000_0000_0000_0001;
    runPos(p, 80, 0);
    p = randPos();
    runPos(p, 80, 0);

    // start during a record with altered inputs (R11)
    p = randPos();
    runPos(p, 60, 1);

    // heavy back-pressure (R9)
    for (int i = 0; i < 5; i++) begin
      p = randPos();
      runPos(p, 20, 0);
    end

    // random positions (R2-R8)
    for (int i = 0; i < 40; i++) begin
      p = randPos();
      runPos(p, 70, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule